// File: doc/BRIEF.md
# Cascadable presettable synchronous counter stage

This block is one stage of a synchronous up-counter. The stage holds a small count word. A parallel preset path can load any value into it. Two count enables gate the increment. A carry output lets several stages be chained into one wider counter that still counts on a single clock edge.

Parameters set the width, the modulus and the clear style. The modulus is either full binary (wrapping after the all-ones value) or decade (wrapping after nine). The clear is either asynchronous or synchronous.

Of the two enables, `cnt_en` only gates counting. `chain_en` gates counting and also qualifies the carry. To build a wider counter, every stage gets the same `cnt_en`. Each stage's `chain_en` is driven from the carry of the stage below it. A stage therefore advances only in the cycle where every lower stage sits at its last value.

Top module: `sync_count_stage`

## Requirements
- R1: In binary mode (`DECADE`=0, `WIDTH`=4), a counting edge takes the count from n to n+1, and from 15 to 0. For example, after a preset of 12 the count steps 13, 14, 15, 0, 1, 2.
- R2: In decade mode (`DECADE`=1), a counting edge takes the count from n to n+1 for n below 9, and from 9 to 0. For example, after a preset of 7 the count steps 8, 9, 0, 1, 2, 3.
- R3: With `clear_n` high and `preset_n` low, a rising edge copies `preset_val` into `count`, whatever the two enables are.
- R4: With `clear_n` and `preset_n` high, a rising edge leaves `count` unchanged unless both `cnt_en` and `chain_en` are high. After the enables return high, counting resumes from the held value, with no state skipped.
- R5: `carry_out` is high exactly when `chain_en` is high and `count` equals the last value of the modulus (15 binary, 9 decade). It is combinational and does not depend on `cnt_en`.
- R6: With `ASYNC_CLR`=0, a low `clear_n` sets `count` to 0 at the next rising edge. Clear takes priority over preset and counting. Before that edge, `count` is unaffected.
- R7: With `ASYNC_CLR`=1, driving `clear_n` low sets `count` to 0 at once, without waiting for a clock edge. The count stays 0 while `clear_n` is low.
- R8: In decade mode, a preset value from 10 to 15 is loaded unchanged. The next counting edge then sets the count to 0.
- R9: Stages chained as described above count as a single binary counter of their combined width. The top stage's carry is high at the all-ones value when the bottom stage's `chain_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all changes except an asynchronous clear happen on its rising edge |
| clear_n | input | 1 | Active-low clear; synchronous or asynchronous according to `ASYNC_CLR` |
| preset_n | input | 1 | Active-low parallel preset |
| cnt_en | input | 1 | Count enable that does not affect the carry |
| chain_en | input | 1 | Count enable that also qualifies the carry; driven from the carry of the stage below in a chain |
| preset_val | input | WIDTH | Value loaded on a preset edge |
| count | output | WIDTH | Current count |
| carry_out | output | 1 | High when `chain_en` is high and the count is at its last value |

## Verification
The clocked assertions treat `clear_n` as a level that is stable across each sampling edge. They also assume that any low phase of `clear_n` covers at least one rising edge. If the clear pulsed low and high again between two edges, an asynchronous stage would drop to zero while the hold and step properties expect the old value.

The stimulus keeps to these assumptions. Every input, clear included, changes only on the falling clock edge, and the clear is held low for at least one full period. Random presets cover the full 4-bit range, so the decade stage regularly receives the out-of-range values 10 to 15.

// File: rtl/cnt_pkg.sv
// Package: shared types and helpers for the counter stage.
// Assumes a decade stage is at least 4 bits wide.
package cnt_pkg;

    // Operation selected for the next rising edge (clear handled separately).
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } cnt_op_e;

    // Last value of the modulus: nine for decade, all ones for binary.
    function automatic int unsigned last_value(int unsigned width, bit decade);
        if (decade) return 9;
        return (1 << width) - 1;
    endfunction

endpackage

// File: rtl/cnt_ctrl.sv
// Control decode: picks load, count or hold from the preset and enable pins.
// Assumes clear has already been handled by the register stage.
module cnt_ctrl
    import cnt_pkg::*;
(
    input  logic    preset_n,
    input  logic    cnt_en,
    input  logic    chain_en,
    output cnt_op_e op
);

    // Preset wins over counting; counting needs both enables.
    always_comb begin
        if (!preset_n)
            op = OP_LOAD;
        else if (cnt_en && chain_en)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/cnt_next.sv
// Next-state logic: computes the value the count register takes on an edge.
// Any value at or above LAST wraps to zero on a count, which also brings an
// out-of-range decade preset back into range.
module cnt_next
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] LAST = '1
) (
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] nxt
);

    // Select the loaded, incremented or held value.
    always_comb begin
        unique case (op)
            OP_LOAD:  nxt = load_val;
            OP_COUNT: nxt = (cur >= LAST) ? '0 : cur + 1'b1;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_carry.sv
// Carry logic: flags the last count value, qualified by the chain enable.
// Purely combinational, so a chain settles within one cycle.
module cnt_carry #(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] LAST = '1
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             chain_en,
    output logic             carry
);

    // Carry when enabled and at the last value.
    always_comb carry = chain_en && (cur == LAST);

endmodule

// File: rtl/sync_count_stage.sv
// Top: one cascadable counter stage with preset, two enables and a carry.
// DECADE selects a 0..9 modulus; ASYNC_CLR selects the clear style.
// Assumes clear_n is held low across at least one rising edge.
module sync_count_stage
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH     = 4,
    parameter bit          DECADE    = 1'b0,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             preset_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] preset_val,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);

    localparam int unsigned      LAST_INT = last_value(WIDTH, DECADE);
    localparam logic [WIDTH-1:0] LAST     = WIDTH'(LAST_INT);

    cnt_op_e          op;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] cnt_q;

    cnt_ctrl u_ctrl (
        .preset_n (preset_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .op       (op)
    );

    cnt_next #(.WIDTH(WIDTH), .LAST(LAST)) u_next (
        .op       (op),
        .cur      (cnt_q),
        .load_val (preset_val),
        .nxt      (nxt)
    );

    cnt_carry #(.WIDTH(WIDTH), .LAST(LAST)) u_carry (
        .cur      (cnt_q),
        .chain_en (chain_en),
        .carry    (carry_out)
    );

    generate
        if (ASYNC_CLR) begin : g_async
            // Count register, cleared at once by a low clear_n.
            always_ff @(posedge clk or negedge clear_n) begin
                if (!clear_n) cnt_q <= '0;
                else          cnt_q <= nxt;
            end

            // R7: count stays zero while clear is held.
            a_r7_async_zero: assert property (@(posedge clk)
                $past(!clear_n) && !clear_n |-> cnt_q == '0);
        end else begin : g_sync
            // Count register, cleared on the edge that samples clear_n low.
            always_ff @(posedge clk) begin
                if (!clear_n) cnt_q <= '0;
                else          cnt_q <= nxt;
            end

            // R6: a sampled low clear gives zero after the edge.
            a_r6_sync_zero: assert property (@(posedge clk)
                !clear_n |=> cnt_q == '0);
        end
    endgenerate

    assign count = cnt_q;

    // R3: preset copies the data word regardless of the enables.
    a_r3_preset: assert property (@(posedge clk) disable iff (!clear_n)
        !preset_n |=> cnt_q == $past(preset_val));

    // R4: a missing enable holds the count.
    a_r4_hold: assert property (@(posedge clk) disable iff (!clear_n)
        preset_n && !(cnt_en && chain_en) |=> $stable(cnt_q));

    // R1/R2: an in-range count step adds one.
    a_r1_step: assert property (@(posedge clk) disable iff (!clear_n)
        preset_n && cnt_en && chain_en && cnt_q < LAST |=> cnt_q == $past(cnt_q) + 1'b1);

    // R2/R8: counting from the last value or beyond returns to zero.
    a_r8_wrap: assert property (@(posedge clk) disable iff (!clear_n)
        preset_n && cnt_en && chain_en && cnt_q >= LAST |=> cnt_q == '0);

    // R5: carry only with chain enable at the last value.
    a_r5_carry_qual: assert property (@(posedge clk) disable iff (!clear_n)
        carry_out |-> chain_en && cnt_q == LAST);

    // R5: a low chain enable always suppresses the carry.
    a_r5_carry_gate: assert property (@(posedge clk) disable iff (!clear_n)
        !chain_en |-> !carry_out);

endmodule

// File: tb/sync_count_stage_tb.sv
module sync_count_stage_tb;

    logic       clk = 1'b0;
    logic       clear_n, preset_n, cnt_en, chain_en;
    logic [3:0] preset_val;
    logic [3:0] q_b, q_d;
    logic       rc_b, rc_d;

    logic        c_clear_n, c_preset_n, c_cnt_en, c_chain_en;
    logic [11:0] c_val, c_count;
    logic [2:0]  c_rc;
    logic [2:0]  c_en;

    int checks = 0;
    int errors = 0;
    logic [3:0]  exp_b, exp_d;
    logic [11:0] exp_c;

    always #5 clk = ~clk;

    // Binary stage, synchronous clear.
    sync_count_stage #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_dut (
        .clk(clk), .clear_n(clear_n), .preset_n(preset_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .preset_val(preset_val), .count(q_b), .carry_out(rc_b));

    // Decade stage, asynchronous clear, same inputs.
    sync_count_stage #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_dec (
        .clk(clk), .clear_n(clear_n), .preset_n(preset_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .preset_val(preset_val), .count(q_d), .carry_out(rc_d));

    // Three binary stages chained carry to chain enable.
    assign c_en[0] = c_chain_en;
    for (genvar i = 0; i < 3; i++) begin : g_chain
        if (i > 0) begin : g_link
            assign c_en[i] = c_rc[i-1];
        end
        sync_count_stage #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_stage (
            .clk(clk), .clear_n(c_clear_n), .preset_n(c_preset_n), .cnt_en(c_cnt_en),
            .chain_en(c_en[i]), .preset_val(c_val[4*i +: 4]),
            .count(c_count[4*i +: 4]), .carry_out(c_rc[i]));
    end

    function automatic logic [3:0] model(logic [3:0] q, bit dec, logic ld, logic ep,
                                         logic et, logic [3:0] d);
        logic [3:0] last = dec ? 4'd9 : 4'd15;
        if (!ld) return d;
        if (ep && et) return (q >= last) ? 4'd0 : q + 4'd1;
        return q;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle on the two single stages; called at a falling edge.
    task automatic cyc(logic c, logic ld, logic ep, logic et, logic [3:0] d);
        logic       was_clr;
        logic [3:0] nb, nd;
        string      tg;
        was_clr = clear_n;
        clear_n = c; preset_n = ld; cnt_en = ep; chain_en = et; preset_val = d;
        #1;
        if (!c && was_clr) begin
            chk(q_d == 4'd0, "R7 async clear immediate", q_d, 0);
            chk(q_b == exp_b, "R6 sync clear waits for edge", q_b, exp_b);
        end
        if (!c) exp_d = 4'd0;
        chk(rc_b == (et && exp_b == 4'd15), "R5 binary carry", rc_b, et && exp_b == 4'd15);
        chk(rc_d == (et && exp_d == 4'd9), "R5 decade carry", rc_d, et && exp_d == 4'd9);
        nb = c ? model(exp_b, 1'b0, ld, ep, et, d) : 4'd0;
        nd = c ? model(exp_d, 1'b1, ld, ep, et, d) : 4'd0;
        if (!c) tg = "R6/R7 clear";
        else if (!ld) tg = "R3 preset";
        else if (ep && et) tg = (exp_d > 4'd9) ? "R8 out-of-range count" : "R1/R2 count";
        else tg = "R4 hold";
        @(posedge clk); @(negedge clk);
        exp_b = nb; exp_d = nd;
        chk(q_b == exp_b, {tg, " binary"}, q_b, exp_b);
        chk(q_d == exp_d, {tg, " decade"}, q_d, exp_d);
    endtask

    // One cycle on the chain; R9.
    task automatic chain_cyc(logic ld, logic ep, logic et, logic [11:0] d);
        logic [11:0] n;
        c_preset_n = ld; c_cnt_en = ep; c_chain_en = et; c_val = d;
        #1;
        chk(c_rc[2] == (et && exp_c == 12'hFFF), "R9 chain top carry", c_rc[2],
            et && exp_c == 12'hFFF);
        if (!ld) n = d;
        else if (ep && et) n = exp_c + 12'd1;
        else n = exp_c;
        @(posedge clk); @(negedge clk);
        exp_c = n;
        chk(c_count == exp_c, "R9 chain count", c_count, exp_c);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        clear_n = 1'b0; preset_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0; preset_val = '0;
        c_clear_n = 1'b0; c_preset_n = 1'b1; c_cnt_en = 1'b0; c_chain_en = 1'b0; c_val = '0;
        @(negedge clk); @(negedge clk);
        exp_b = 4'd0; exp_d = 4'd0; exp_c = 12'd0;
        chk(q_b == 4'd0, "R6 reset state", q_b, 0);
        chk(q_d == 4'd0, "R7 reset state", q_d, 0);
        chk(c_count == 12'd0, "R9 reset state", c_count, 0);
        c_clear_n = 1'b1;

        // R1: preset twelve, count through the wrap.
        cyc(1, 0, 0, 0, 4'd12);
        for (int i = 0; i < 6; i++) cyc(1, 1, 1, 1, 4'd0);
        // R2: preset seven, count through the decade wrap.
        cyc(1, 0, 1, 1, 4'd7);
        for (int i = 0; i < 6; i++) cyc(1, 1, 1, 1, 4'd0);
        // R4: hold with each enable low, then resume.
        cyc(1, 0, 1, 1, 4'd8);
        cyc(1, 1, 0, 1, 4'd0);
        cyc(1, 1, 1, 0, 4'd0);
        cyc(1, 1, 0, 0, 4'd0);
        cyc(1, 1, 1, 1, 4'd0);
        // R5: at terminal with cnt_en low, carry follows chain_en only.
        cyc(1, 0, 0, 0, 4'd9);
        cyc(1, 1, 0, 1, 4'd0);
        cyc(1, 1, 0, 0, 4'd0);
        cyc(1, 0, 0, 0, 4'd15);
        cyc(1, 1, 0, 1, 4'd0);
        // R8: decade out-of-range preset, then count.
        cyc(1, 0, 0, 0, 4'd13);
        cyc(1, 1, 1, 1, 4'd0);
        // R6/R7: clear over preset and count.
        cyc(1, 0, 0, 0, 4'd5);
        cyc(0, 0, 1, 1, 4'd3);
        cyc(0, 1, 1, 1, 4'd3);
        cyc(1, 1, 1, 1, 4'd0);

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            logic c, ld, ep, et;
            c  = ($urandom % 20) != 0;
            ld = ($urandom % 6) != 0;
            ep = ($urandom % 4) != 0;
            et = ($urandom % 4) != 0;
            cyc(c, ld, ep, et, 4'($urandom));
        end
        cyc(1, 1, 0, 0, 4'd0);

        // R9: chained stages through the full wrap.
        chain_cyc(0, 0, 0, 12'hFFC);
        for (int i = 0; i < 6; i++) chain_cyc(1, 1, 1, 12'd0);
        chain_cyc(0, 0, 0, 12'h0FE);
        for (int i = 0; i < 4; i++) chain_cyc(1, 1, 1, 12'd0);
        for (int i = 0; i < 300; i++) begin
            logic ld, ep, et;
            ld = ($urandom % 40) != 0;
            ep = ($urandom % 4) != 0;
            et = ($urandom % 4) != 0;
            chain_cyc(ld, ep, et, 12'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule